// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous 128K x 8 static RAM. It turns each single-word request from the host into a timed sequence of strobes on the memory pins. The host presents a request with a valid/ready handshake. The request carries a write flag, a 17-bit address and, for a write, one data byte. A read returns its byte together with a one-cycle done pulse.

The memory is selected through two enables of opposite polarity. A read holds the output strobe low while the write strobe stays high. A write pulses the write strobe low while the output strobe stays high. Every analog limit is a parameter given in nanoseconds, along with the clock period. The controller turns each limit into a whole number of clock cycles, never fewer than one. The memory data bus is bidirectional, so the controller splits it into an output, an output enable and an input. It keeps its own drivers off during every phase in which the memory might still be driving the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the select pin `mem_sel_n` is HIGH, `mem_sel` is LOW, `mem_oe_n` and `mem_we_n` are HIGH, `mem_dq_oe` is LOW, `rsp_done` is LOW and `req_ready` is HIGH.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both HIGH. `req_ready` is LOW from the cycle after acceptance until the access and its recovery or turnaround have completed.
- R3: During a read, both enables are active, `mem_we_n` is HIGH and `mem_oe_n` is LOW. The address stays stable for exactly RD cycles. RD is the largest of ceil(T_AA/CLK), ceil(T_DOE/CLK) and ceil(T_RC/CLK). It is 9 at the defaults.
- R4: Read data is registered from `mem_dq_in` on the last read cycle. `rsp_done` is HIGH for exactly one cycle, RD cycles after the accepting edge, with `rsp_rdata` holding that byte.
- R5: During a write, both enables are active and `mem_we_n` is LOW for exactly WP cycles. WP is the largest of ceil(T_PWE/CLK), ceil(T_SD/CLK) and ceil(T_AW/CLK). It is 8 at the defaults. `mem_oe_n` is HIGH throughout, and the write byte is driven for the whole pulse.
- R6: After the write pulse there is a recovery phase of max(1, ceil(T_WC/CLK) - WP) cycles, with data still driven. `req_ready` returns WP plus that many cycles after acceptance, which is 9 cycles at the defaults.
- R7: After each read, `mem_oe_n` is HIGH and the drivers are off for HZ = max(1, ceil(T_HZOE/CLK)) cycles before the next request can be accepted. HZ is 4 at the defaults. `mem_dq_oe` is never HIGH while `mem_oe_n` is LOW.
- R8: While the controller is idle, the memory is deselected (`mem_sel_n` HIGH, `mem_sel` LOW) and both strobes are HIGH. A LOW `req_valid` leaves the memory untouched.
- R9: Each phase counter runs down by one per cycle from its loaded length, so every phase lasts exactly its computed cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Read byte, valid with rsp_done |
| rsp_done | output | 1 | One-cycle read completion pulse |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data seen on the memory bus |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts the request. A read's done pulse is due RD cycles after that edge, and ready returns RD+HZ cycles after it. A write's ready returns WP plus the recovery cycles after it, and its strobe edges show up on the memory pins right after each edge. The driver notes the accepting edge, and the scoreboard entry carries the cycle at which its done pulse is due. All outputs are sampled on the falling clock edge, half a cycle after they change. The bench's memory model counts strobe widths and turnaround gaps in those falling-edge samples and compares them with the bench's own cycle formulas.

// File: rtl/asram_pkg.sv
// Package: shared state type and cycle-count helpers for the static RAM controller.
// Assumes all timing values are non-negative integers in nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_RHZ    = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WREC   = 3'd4
    } asram_state_e;

    // Whole cycles covering t_ns at period clk_ns, never fewer than one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned clk_ns);
        int unsigned q;
        q = (t_ns + clk_ns - 1) / clk_ns;
        return (q < 1) ? 1 : q;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Module: down-counter that measures the length of one strobe phase.
// Assumes load is pulsed on the cycle a phase is entered, with length-1.
// expired is HIGH on the last cycle of the phase.
module asram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Last cycle of the phase.
    always_comb expired = (cnt_q == '0);

    // R9: without a load, the counter moves down by exactly one.
    a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/asram_capture.sv
// Module: registers the byte on the memory bus at the end of a read and
// raises a one-cycle done pulse. Assumes capture_en lasts a single cycle.
module asram_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    // Hold the captured byte until the next read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture_en) begin
            rdata <= bus_in;
        end
    end

    // Done follows the capture by one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= capture_en;
        end
    end

    // R4: done never lasts longer than one cycle.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/asram_seq.sv
// Module: access sequencer. It accepts host requests and steps through the
// read, turnaround, write-pulse and recovery phases. It drives all memory
// pins from registers so the external strobes do not glitch. Phase lengths
// come in as cycle counts, each at least one.
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned RD_CYC = 9,
    parameter int unsigned WP_CYC = 8,
    parameter int unsigned WR_CYC = 1,
    parameter int unsigned HZ_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_expired,
    output logic              capture_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LAST = CNT_W'(HZ_CYC - 1);

    asram_state_e state_q, state_d;
    logic         accept;
    logic         sel_d;

    // Handshake: idle means ready; a request is taken only when both are high.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    // Phase transitions and timer loads.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WPULSE;
                        tmr_val = WP_LAST;
                    end else begin
                        state_d = ST_READ;
                        tmr_val = RD_LAST;
                    end
                end
            end
            ST_READ: begin
                if (tmr_expired) begin
                    state_d  = ST_RHZ;
                    tmr_load = 1'b1;
                    tmr_val  = HZ_LAST;
                end
            end
            ST_RHZ: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_WPULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = WR_LAST;
                end
            end
            ST_WREC: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Capture strobe on the last read cycle.
    always_comb capture_en = (state_q == ST_READ) && tmr_expired;

    // Selection in the next state: read, write pulse and write recovery.
    always_comb sel_d = (state_d == ST_READ) || (state_d == ST_WPULSE) ||
                        (state_d == ST_WREC);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Latch address and write byte at acceptance; hold for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Registered memory strobes, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_sel_n <= !sel_d;
            mem_sel   <= sel_d;
            mem_oe_n  <= (state_d != ST_READ);
            mem_we_n  <= (state_d != ST_WPULSE);
            mem_dq_oe <= (state_d == ST_WPULSE) || (state_d == ST_WREC);
        end
    end

    // R2: an accepted request makes the controller busy on the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: while idle, the memory is deselected and both strobes are high.
    a_r8_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n));

endmodule

// File: rtl/asram_ctrl.sv
// Module: top of the asynchronous static RAM controller. It converts the
// nanosecond limits into phase cycle counts and connects the sequencer,
// the phase timer and the read capture. Assumes CLK_NS is the real clock
// period and that the memory meets the limits given as parameters.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_DOE_NS  = 35,
    parameter int unsigned T_HZOE_NS = 25,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_PWE_NS  = 50,
    parameter int unsigned T_SD_NS   = 30,
    parameter int unsigned T_AW_NS   = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int unsigned RD_CYC = max3(ns_to_cycles(T_AA_NS, CLK_NS),
                                          ns_to_cycles(T_DOE_NS, CLK_NS),
                                          ns_to_cycles(T_RC_NS, CLK_NS));
    localparam int unsigned WP_CYC = max3(ns_to_cycles(T_PWE_NS, CLK_NS),
                                          ns_to_cycles(T_SD_NS, CLK_NS),
                                          ns_to_cycles(T_AW_NS, CLK_NS));
    localparam int unsigned WC_CYC = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int unsigned WR_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned HZ_CYC = ns_to_cycles(T_HZOE_NS, CLK_NS);
    localparam int unsigned MAX_CYC = max3(max3(RD_CYC, WP_CYC, WR_CYC), HZ_CYC, 2);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             capture_en;

    asram_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .WR_CYC (WR_CYC),
        .HZ_CYC (HZ_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_expired (tmr_expired),
        .capture_en  (capture_en),
        .mem_addr    (mem_addr),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .mem_sel_n   (mem_sel_n),
        .mem_sel     (mem_sel),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n)
    );

    asram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .bus_in     (mem_dq_in),
        .rdata      (rsp_rdata),
        .done       (rsp_done)
    );

    // R7: the controller never drives while the memory's outputs may be on.
    a_r7_drive_needs_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5: output enable stays high for every write-pulse cycle.
    a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R3: the address does not move while a read is in progress.
    a_r3_addr_hold_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

endmodule

// File: tb/asram_ctrl_tb.sv
// Bench: behavioural static RAM model plus scoreboard. The driver task pushes
// expected read bytes and their due cycles; a monitor pops them on done.
module asram_ctrl_tb;

    localparam int CLK = 8;
    // Cycle counts worked out from the default ns limits at an 8 ns clock.
    localparam int RD = 9;   // max(ceil70/8, ceil35/8, ceil70/8)
    localparam int WP = 8;   // max(ceil50/8, ceil30/8, ceil60/8)
    localparam int WR = 1;   // max(1, ceil70/8 - WP)
    localparam int HZ = 4;   // ceil25/8

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0] marr   [0:255];
    logic [7:0] shadow [0:255];

    typedef struct { logic [7:0] data; int due; } exp_t;
    exp_t sb_q[$];

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    always #(CLK/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Memory model: drives the bus only when selected, OE low, WE high.
    always_comb begin
        if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
            mem_dq_in = marr[mem_addr[7:0]];
        else if (mem_dq_oe)
            mem_dq_in = mem_dq_out;
        else
            mem_dq_in = 8'h00;
    end

    // Pin monitor: strobe widths, write capture, turnaround and done pulse.
    int         wcnt = 0, rcnt = 0, oe_rise = -100;
    logic       p_wlow = 1'b0, p_rd = 1'b0, p_dqoe = 1'b0, p_done = 1'b0;
    logic       w_bad = 1'b0, r_bad = 1'b0;
    logic [16:0] p_addr = '0, r_addr = '0;
    logic [7:0]  p_data = '0;
    always @(negedge clk) begin
        logic wlow, rd;
        if (rst_n) begin
            wlow = !mem_sel_n && mem_sel && !mem_we_n;
            rd   = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
            if (wlow) begin
                wcnt++;
                if (!mem_oe_n || !mem_dq_oe) w_bad = 1'b1;
            end
            if (p_wlow && !wlow) begin
                marr[p_addr[7:0]] = p_data;
                chk(wcnt == WP, "R5 write pulse width", wcnt, WP);
                chk(!w_bad, "R5 oe high and data driven in pulse", w_bad, 0);
                wcnt = 0; w_bad = 1'b0;
            end
            if (rd) begin
                if (rcnt == 0) r_addr = mem_addr;
                else if (mem_addr != r_addr) r_bad = 1'b1;
                rcnt++;
            end
            if (p_rd && !rd) begin
                chk(rcnt == RD && !r_bad, "R3 read window", rcnt, RD);
                oe_rise = cyc; rcnt = 0; r_bad = 1'b0;
            end
            if (!p_dqoe && mem_dq_oe)
                chk(cyc - oe_rise >= HZ, "R7 turnaround gap", cyc - oe_rise, HZ);
            if (rd && mem_dq_oe)
                chk(0, "R7 bus contention", 1, 0);
            if (rsp_done) begin
                chk(!p_done, "R4 done single cycle", p_done, 0);
                if (sb_q.size() == 0) begin
                    chk(0, "R4 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(rsp_rdata == e.data, "R4 read data", rsp_rdata, e.data);
                    chk(cyc == e.due, "R4 done latency", cyc, e.due);
                end
            end
            p_wlow = wlow; p_rd = rd; p_dqoe = mem_dq_oe; p_done = rsp_done;
            p_addr = mem_addr; p_data = mem_dq_out;
        end
    end

    // Driver: one access, with the ready-return cycle checked.
    task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d);
        int acc;
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        if (wr) begin
            shadow[a[7:0]] = d;
        end else begin
            e.data = shadow[a[7:0]]; e.due = acc + RD;
            sb_q.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0; req_wdata = ~d;
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
        if (wr) chk(cyc == acc + WP + WR, "R6 write ready return", cyc - acc, WP + WR);
        else    chk(cyc == acc + RD + HZ, "R7 read ready return", cyc - acc, RD + HZ);
        chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R8 idle deselect", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            marr[i] = 8'(i) ^ 8'h3C;
            shadow[i] = 8'(i) ^ 8'h3C;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done && req_ready,
            "R1 reset state", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done, req_ready},
            7'b1011001);
        rst_n = 1'b1;
        // R8: no valid means no memory activity
        repeat (5) @(negedge clk);
        chk(mem_sel_n && !mem_sel && !rsp_done, "R8 no request no access", mem_sel_n, 1);
        access(1'b1, 17'h00000, 8'hA5);
        access(1'b1, 17'h1FFFF, 8'h5A);
        access(1'b1, 17'h00012, 8'h00);
        access(1'b1, 17'h0AB34, 8'hFF);
        access(1'b0, 17'h00000, 8'h00);
        access(1'b0, 17'h1FFFF, 8'h00);
        access(1'b0, 17'h00077, 8'h00);
        access(1'b1, 17'h00077, 8'hC3);   // R7 write right after a read
        access(1'b0, 17'h00077, 8'h00);
        access(1'b0, 17'h00012, 8'h00);
        access(1'b0, 17'h0AB34, 8'h00);
        for (int k = 0; k < 6; k++) begin
            access(1'b1, 17'(k * 40 + 3), 8'(k * 37 + 1));
            access(1'b0, 17'(k * 40 + 3), 8'h00);
        end
        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R4 all reads completed", sb_q.size(), 0);
        chk(marr[8'h34] == 8'hFF, "R5 stored byte", marr[8'h34], 8'hFF);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule